// File: doc/BRIEF.md
# Skip-Capable Read Port Controller

This block is the read side of a sequential-access field buffer. It owns the read pointer and a registered output word. It also decides when the data bus is driven. Three control strobes come in on the read clock: a pointer reset, a read enable and an output enable. A polarity input sets the active level of all three, so the block can face either convention without glue logic.

The block reads the memory at the address it presents on `rd_addr_o`, and that data comes back combinationally on `mem_data_i`. On each enabled cycle the word is captured into the output register and the pointer moves on. When output enable is inactive, the pointer still advances but the bus is released, so the skipped words never reach the bus. A pointer reset that arrives while reads are disabled is not lost. It is held pending and carried out by the next enabled cycle.

The bus tri-state is modelled as two flags. `dout_valid_o` says that the output register holds a word read since the global reset. `bus_drive_o` is the drive enable for the pad.

Top module: `skip_read_port`

## Requirements
- R1: With `pol_i`=0 the strobes `rrst_i`, `ren_i` and `oe_i` are active high. With `pol_i`=1 all three are active low.
- R2: On a normal read (enable and output enable active, reset inactive and none pending), the edge loads `dout_o` with the word at the current pointer, sets `bus_drive_o`, and adds one to the pointer.
- R3: On a skip (enable active, output enable inactive, no reset), the edge adds one to the pointer and clears `bus_drive_o`.
- R4: With enable inactive the pointer and `dout_o` hold. `bus_drive_o` still follows output enable at each edge.
- R5: On an enabled cycle with reset active, `rd_addr_o` is 0 and the word at address 0 is loaded. The next enabled read then uses address 1.
- R6: A reset seen while enable is inactive is kept pending. The first enabled cycle afterwards acts as a reset cycle (address 0), even if the reset strobe has been released by then.
- R7: A pending reset is cleared by the enabled cycle that carries it out, and by the asynchronous global reset.
- R8: The pointer wraps from 2^AW-1 to 0.
- R9: While `rst_ni` is low, the pointer, `dout_o`, `dout_valid_o` and `bus_drive_o` are all 0.
- R10: `dout_valid_o` rises on the first enabled cycle after the global reset and then stays high.
- R11: `rd_addr_o` equals the pointer, except on an enabled cycle with a reset active or pending, when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock, rising edge |
| rst_ni | input | 1 | Asynchronous global reset, active low |
| pol_i | input | 1 | Strobe polarity: 1 selects active-low strobes |
| rrst_i | input | 1 | Read pointer reset strobe |
| ren_i | input | 1 | Read enable strobe |
| oe_i | input | 1 | Output enable strobe |
| mem_data_i | input | DW | Memory word at `rd_addr_o` |
| rd_addr_o | output | AW | Memory read address |
| dout_o | output | DW | Registered output word |
| dout_valid_o | output | 1 | Output register holds a word read since reset |
| bus_drive_o | output | 1 | Data bus drive enable |

## Verification
The bench raises a reset while reads are disabled, then drops it before enable returns. A design that forgets the pending reset carries on from the stale pointer. The bench follows that pending reset with a second enabled read. A design that never clears the pending flag returns address 0 twice.

Skipped runs show whether the pointer keeps moving while the bus is released. A design that stalls the pointer there returns the skipped words afterwards. A long run past the top address catches a pointer that saturates or overflows wrongly. The same traffic repeated with the polarity input set to 1 catches any strobe decoded at a fixed level.

// File: rtl/skip_rd_pkg.sv
package skip_rd_pkg;

    // Strobes after polarity decoding: 1 means asserted.
    typedef struct packed {
        logic rst;
        logic en;
        logic oe;
    } rd_ctrl_t;

    localparam int unsigned CTRL_W = 3;

endpackage

// File: rtl/srp_pol_norm.sv
module srp_pol_norm
    import skip_rd_pkg::*;
(
    input  logic     pol_i,
    input  logic     rrst_i,
    input  logic     ren_i,
    input  logic     oe_i,
    output rd_ctrl_t ctrl_o
);

    logic [CTRL_W-1:0] raw;
    logic [CTRL_W-1:0] act;

    assign raw = {rrst_i, ren_i, oe_i};

    // A high polarity pin inverts every strobe.
    for (genvar i = 0; i < CTRL_W; i++) begin : g_norm
        assign act[i] = raw[i] ^ pol_i;
    end

    assign ctrl_o = rd_ctrl_t'(act);

endmodule

// File: rtl/srp_ptr_unit.sv
module srp_ptr_unit
    import skip_rd_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  rd_ctrl_t      ctrl_i,
    output logic [AW-1:0] rd_addr_o
);

    localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          pend;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       rst_now;

    always_comb begin
        st_d    = st_q;
        rst_now = ctrl_i.en && (ctrl_i.rst || st_q.pend);
        rd_addr_o = rst_now ? '0 : st_q.ptr;
        if (ctrl_i.en) begin
            st_d.ptr  = rd_addr_o + ADDR_ONE;
            st_d.pend = 1'b0;
        end else if (ctrl_i.rst) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i.en |=> $stable(st_q.ptr));

    // R6
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_i.en && ctrl_i.rst) |=> st_q.pend);

    // R7
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_i.en |=> !st_q.pend);

    // R5
    rst_next_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.en && (ctrl_i.rst || st_q.pend)) |=> (st_q.ptr == ADDR_ONE));

    // R8
    ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i.en && !ctrl_i.rst && !st_q.pend && st_q.ptr == ADDR_MAX)
        |=> (st_q.ptr == '0));

endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage
    import skip_rd_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  rd_ctrl_t      ctrl_i,
    input  logic [DW-1:0] mem_data_i,
    output logic [DW-1:0] dout_o,
    output logic          valid_o,
    output logic          drive_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          drive;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drive = ctrl_i.oe;
        if (ctrl_i.en) begin
            st_d.data  = mem_data_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign drive_o = st_q.drive;

    // R4
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i.en |=> $stable(st_q.data));

    // R10
    valid_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_i.en |=> st_q.valid);

    // R2
    drive_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_i.oe |=> st_q.drive);

    // R3
    drive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_i.oe |=> !st_q.drive);

endmodule

// File: rtl/skip_read_port.sv
module skip_read_port
    import skip_rd_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pol_i,
    input  logic          rrst_i,
    input  logic          ren_i,
    input  logic          oe_i,
    input  logic [DW-1:0] mem_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [DW-1:0] dout_o,
    output logic          dout_valid_o,
    output logic          bus_drive_o
);

    rd_ctrl_t ctrl;

    srp_pol_norm u_pol (
        .pol_i  (pol_i),
        .rrst_i (rrst_i),
        .ren_i  (ren_i),
        .oe_i   (oe_i),
        .ctrl_o (ctrl)
    );

    srp_ptr_unit #(.AW(AW)) u_ptr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctrl_i    (ctrl),
        .rd_addr_o (rd_addr_o)
    );

    srp_out_stage #(.DW(DW)) u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctrl_i     (ctrl),
        .mem_data_i (mem_data_i),
        .dout_o     (dout_o),
        .valid_o    (dout_valid_o),
        .drive_o    (bus_drive_o)
    );

    // R9
    reset_idle_chk: assert property (@(posedge clk_i)
        !rst_ni |-> (!dout_valid_o && !bus_drive_o && dout_o == '0));

endmodule

// File: tb/skip_read_port_tb.sv
module skip_read_port_tb;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pol = 1'b0;
    logic          rrst, ren, oe;
    logic [DW-1:0] mem_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] dout;
    logic          dvalid, drive;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_ptr = 0;
    int m_pend = 0;
    int m_dout = 0;
    int m_valid = 0;
    int m_drive = 0;
    int cur_rst = 0, cur_en = 0, cur_oe = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return DW'((int'(a) * 613 + 17) & 16'hFFFF);
    endfunction

    assign mem_data = word_at(rd_addr);

    skip_read_port #(.DW(DW), .AW(AW)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pol_i        (pol),
        .rrst_i       (rrst),
        .ren_i        (ren),
        .oe_i         (oe),
        .mem_data_i   (mem_data),
        .rd_addr_o    (rd_addr),
        .dout_o       (dout),
        .dout_valid_o (dvalid),
        .bus_drive_o  (drive)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_addr();
        return (cur_en != 0 && (cur_rst != 0 || m_pend != 0)) ? 0 : m_ptr;
    endfunction

    task automatic check_regs(input string tag);
        check(tag, "dout", int'(dout), m_dout);
        check(tag, "valid", int'(dvalid), m_valid);
        check(tag, "drive", int'(drive), m_drive);
    endtask

    // One read-clock cycle with logical strobe levels; pins carry the polarity.
    task automatic step(input string tag, input int r, input int e, input int o);
        int a;
        cur_rst = r; cur_en = e; cur_oe = o;
        rrst = logic'(r != 0) ^ pol;
        ren  = logic'(e != 0) ^ pol;
        oe   = logic'(o != 0) ^ pol;
        #1;
        // R11
        check(tag, "rd_addr", int'(rd_addr), model_addr());
        @(posedge clk);
        a = model_addr();
        m_drive = o;
        if (e != 0) begin
            m_dout  = int'(word_at(AW'(a)));
            m_valid = 1;
            m_ptr   = (a + 1) % DEPTH;
            m_pend  = 0;
        end else if (r != 0) begin
            m_pend = 1;
        end
        @(negedge clk);
        check_regs(tag);
    endtask

    task automatic global_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rrst = pol; ren = pol; oe = pol;
        m_ptr = 0; m_pend = 0; m_dout = 0; m_valid = 0; m_drive = 0;
        repeat (2) @(negedge clk);
        // R9
        check_regs("R9");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rrst = 1'b0; ren = 1'b0; oe = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check_regs("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R9");

        // R5 reset with enable; R10 valid rises
        step("R5", 1, 1, 1);
        check("R10", "valid", int'(dvalid), 1);
        for (int i = 0; i < 5; i++) step("R2", 0, 1, 1);
        for (int i = 0; i < 3; i++) step("R3", 0, 1, 0);
        for (int i = 0; i < 2; i++) step("R2", 0, 1, 1);
        step("R4", 0, 0, 1);
        step("R4", 0, 0, 0);
        step("R4", 0, 0, 1);
        // R6 reset while disabled, released before enable returns
        step("R6", 1, 0, 1);
        step("R6", 0, 0, 1);
        step("R6", 0, 0, 0);
        step("R6", 0, 1, 1);
        // R7 pending cleared by the applying cycle
        step("R7", 0, 1, 1);
        step("R7", 0, 1, 1);
        // skip across a pending reset with output disabled
        step("R6", 1, 0, 0);
        step("R3", 0, 1, 0);
        step("R7", 0, 1, 1);

        // R8 wrap
        for (int i = 0; i < DEPTH + 6; i++) step("R8", 0, 1, (i % 7 == 3) ? 0 : 1);

        // R7 global reset drops a pending reset
        step("R7", 1, 0, 1);
        global_reset();
        step("R7", 0, 1, 1);
        step("R7", 0, 1, 1);

        // R1 active-low strobes
        pol = 1'b1;
        global_reset();
        step("R1", 0, 0, 0);
        step("R1", 1, 1, 1);
        for (int i = 0; i < 4; i++) step("R1", 0, 1, 1);
        step("R1", 0, 1, 0);
        step("R1", 1, 0, 1);
        step("R1", 0, 1, 1);
        step("R1", 0, 1, 1);
        step("R1", 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule